// File: doc/BRIEF.md
# Self-Timed SRAM Access Sequencer

This block sequences one access of a single-port synchronous SRAM macro. On a rising clock edge it decides whether to start an access, and from then on it drives the strobes of the array: word-line enable, bit-line enable, replica (dummy) word-line select, sense-amplifier enable, write-driver enable and a word-line reset strobe. The end of an access is not set by a fixed number of clocks. It is set by a replica bit-line completion event.

In silicon that event comes from a replica column. Here a synthesizable stand-in models it as a down-counter whose start value comes from a 4-bit adjust input. The start value is doubled when the low-power mode is selected. Read data arrives from the sense amplifiers on `sa_data`. It is captured while the sense strobe is high, and it is then held on `rd_data` until the next read completes. All pins are plain control or status signals and carry no handshake. `busy` tells the surrounding logic when a new command may be accepted. A command presented while `busy` is high is dropped, not queued.

Top module: `sram_access_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every strobe, `busy`, `dw_mode` and `rd_data` are 0 after that edge.
- R2: An access starts only at an edge where the sequencer is idle, `cs_n` is 0 and `sleep_n` is 1. Otherwise `busy` stays 0 and all strobes stay 0.
- R3: `rd_wr` = 1 selects a read and `rd_wr` = 0 selects a write. `dw_mode` holds the sampled `rd_wr` for the whole access. `sa_en` is asserted only in reads and `wd_en` only in writes.
- R4: In the first cycle after an accepting edge, `wl_en`, `bl_en` and `dwl_sel` are all 1 and `busy` is 1.
- R5: The replica delay L is `trim` when `perf_n` = 1 and 2×`trim` when `perf_n` = 0, both sampled at the accepting edge. Completion occurs L cycles after acceptance.
- R6: In a read, `sa_en` is high for exactly one cycle, which is cycle index L+1 of the access (index 0 is the first busy cycle).
- R7: In a read, `rd_data` takes the value of `sa_data` sampled at the edge that ends the `sa_en` cycle. It is unchanged by writes and by aborted accesses.
- R8: In a write, `wd_en` and `wl_en` stay high for L+1 cycles, then both fall at the edge after completion.
- R9: Every completed access ends with a single-cycle `wl_rst` pulse with `wl_en` low, in its last busy cycle.
- R10: `busy` lasts L+3 cycles for a read and L+2 cycles for a write. Edges seen while busy are ignored, even with `cs_n` low and other controls changed.
- R11: At an edge with `sleep_n` = 0, any access is abandoned. After that edge all strobes and `busy` are 0 and remain 0 while `sleep_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything acts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Access request, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| perf_n | input | 1 | 1 = fast mode, 0 = low-power mode (doubles replica delay) |
| sleep_n | input | 1 | Active-low sleep; blocks and aborts accesses |
| trim | input | 4 | Replica discharge adjust value |
| sa_data | input | 16 | Data from sense amplifiers |
| rd_data | output | 16 | Latched read data |
| wl_en | output | 1 | Word-line enable |
| bl_en | output | 1 | Bit-line enable |
| dwl_sel | output | 1 | Replica word-line select |
| dw_mode | output | 1 | Buffered access type passed to replica path |
| sa_en | output | 1 | Sense-amplifier enable pulse |
| wd_en | output | 1 | Write-driver enable |
| wl_rst | output | 1 | Word-line reset strobe |
| busy | output | 1 | High while an access is in progress |

## Verification
The hardest situations to reach from the ports are an edge that lands while an access is running and a sleep request that arrives partway through a replica discharge. The driver keeps `cs_n` low for every busy cycle, with the access type, mode and adjust value flipped, and it releases the request in the same half-cycle that `busy` is seen low. Any command that leaks through then shows up as a wrong busy length or a change in `dw_mode`. Sleep is asserted during a slow-mode access with the largest adjust value, so the sequencer is still partway through the discharge. The bench then checks that the strobes drop and the read latch is left alone.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_SENSE  = 2'd2,
    ST_WLRST  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seq_cmd_decode.sv
`timescale 1ns/1ps
module seq_cmd_decode (
  input  logic idle,
  input  logic cs_n,
  input  logic sleep_n,
  output logic accept
);
  // A start needs an idle sequencer, a selected chip and an awake macro.
  always_comb accept = idle && !cs_n && sleep_n;
endmodule

// File: rtl/replica_timer.sv
`timescale 1ns/1ps
module replica_timer #(
  parameter int TRIM_W = 4,
  localparam int CNT_W = TRIM_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              slow,
  input  logic [TRIM_W-1:0] trim,
  input  logic              run,
  output logic              done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= slow ? {trim, 1'b0} : {1'b0, trim};
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb done = run && (cnt_q == '0);

  // R5: while running, the count never rises
  a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/strobe_fsm.sv
`timescale 1ns/1ps
module strobe_fsm
  import sram_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic rd_wr,
  input  logic sleep_n,
  input  logic done,
  output logic idle,
  output logic wl_en,
  output logic bl_en,
  output logic dwl_sel,
  output logic dw_mode,
  output logic sa_en,
  output logic wd_en,
  output logic wl_rst,
  output logic busy
);
  seq_state_t st_q;

  always_comb idle = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !sleep_n) begin
      st_q    <= ST_IDLE;
      wl_en   <= 1'b0;
      bl_en   <= 1'b0;
      dwl_sel <= 1'b0;
      sa_en   <= 1'b0;
      wd_en   <= 1'b0;
      wl_rst  <= 1'b0;
      busy    <= 1'b0;
      if (rst) dw_mode <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_ACCESS;
          wl_en   <= 1'b1;
          bl_en   <= 1'b1;
          dwl_sel <= 1'b1;
          dw_mode <= rd_wr;
          wd_en   <= !rd_wr;
          busy    <= 1'b1;
        end
        ST_ACCESS: if (done) begin
          dwl_sel <= 1'b0;
          if (dw_mode) begin
            st_q  <= ST_SENSE;
            sa_en <= 1'b1;
          end else begin
            st_q   <= ST_WLRST;
            wl_en  <= 1'b0;
            bl_en  <= 1'b0;
            wd_en  <= 1'b0;
            wl_rst <= 1'b1;
          end
        end
        ST_SENSE: begin
          st_q   <= ST_WLRST;
          sa_en  <= 1'b0;
          wl_en  <= 1'b0;
          bl_en  <= 1'b0;
          wl_rst <= 1'b1;
        end
        default: begin
          st_q   <= ST_IDLE;
          wl_rst <= 1'b0;
          busy   <= 1'b0;
        end
      endcase
    end
  end

  a_r4_open_together: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (wl_en && bl_en && dwl_sel));
  a_r6_sense_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(sa_en) |-> $past(done));
  a_r6_sense_pulse: assert property (@(posedge clk) disable iff (rst)
    sa_en |=> !sa_en);
  a_r3_sense_reads_only: assert property (@(posedge clk) disable iff (rst)
    sa_en |-> dw_mode);
  a_r3_drive_writes_only: assert property (@(posedge clk) disable iff (rst)
    wd_en |-> !dw_mode);
  a_r8_write_release: assert property (@(posedge clk) disable iff (rst)
    ($fell(wd_en) && $past(sleep_n)) |-> ($past(done) && !wl_en));
  a_r9_reset_strobe: assert property (@(posedge clk) disable iff (rst)
    ($fell(wl_en) && $past(sleep_n)) |-> wl_rst);
  a_r9_reset_pulse: assert property (@(posedge clk) disable iff (rst)
    wl_rst |=> !wl_rst);
  a_r10_busy_cover: assert property (@(posedge clk) disable iff (rst)
    (wl_en || sa_en || wl_rst) |-> busy);
  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    !sleep_n |=> !(wl_en || bl_en || dwl_sel || sa_en || wd_en || wl_rst || busy));
endmodule

// File: rtl/read_latch.sv
`timescale 1ns/1ps
module read_latch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (capture) dout <= din;
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(capture) |-> $stable(dout));
endmodule

// File: rtl/sram_access_seq.sv
`timescale 1ns/1ps
module sram_access_seq #(
  parameter int TRIM_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic              perf_n,
  input  logic              sleep_n,
  input  logic [TRIM_W-1:0] trim,
  input  logic [DATA_W-1:0] sa_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wl_en,
  output logic              bl_en,
  output logic              dwl_sel,
  output logic              dw_mode,
  output logic              sa_en,
  output logic              wd_en,
  output logic              wl_rst,
  output logic              busy
);
  logic idle, accept, rep_done;

  seq_cmd_decode u_dec (
    .idle(idle), .cs_n(cs_n), .sleep_n(sleep_n), .accept(accept)
  );

  replica_timer #(.TRIM_W(TRIM_W)) u_rep (
    .clk(clk), .rst(rst || !sleep_n), .load(accept), .slow(!perf_n),
    .trim(trim), .run(dwl_sel), .done(rep_done)
  );

  strobe_fsm u_fsm (
    .clk(clk), .rst(rst), .accept(accept), .rd_wr(rd_wr), .sleep_n(sleep_n),
    .done(rep_done), .idle(idle), .wl_en(wl_en), .bl_en(bl_en),
    .dwl_sel(dwl_sel), .dw_mode(dw_mode), .sa_en(sa_en), .wd_en(wd_en),
    .wl_rst(wl_rst), .busy(busy)
  );

  read_latch #(.DATA_W(DATA_W)) u_lat (
    .clk(clk), .rst(rst), .capture(sa_en), .din(sa_data), .dout(rd_data)
  );

  a_r2_start_gate: assert property (@(posedge clk) disable iff (rst)
    (!busy && (cs_n || !sleep_n)) |=> !busy);
endmodule

// File: tb/test_sram_access_seq.sv
`timescale 1ns/1ps
module test_sram_access_seq;
  logic clk = 0, rst = 1, cs_n = 1, rd_wr = 1, perf_n = 1, sleep_n = 1;
  logic [3:0] trim = 0;
  logic [15:0] sa_data = 0;
  logic [15:0] rd_data;
  logic wl_en, bl_en, dwl_sel, dw_mode, sa_en, wd_en, wl_rst, busy;
  int n_run = 0, n_fail = 0;
  bit mon_en = 0;
  logic [15:0] last_rd = 0;

  always #2.5 clk = ~clk;

  sram_access_seq i_sram_access_seq (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_wr(rd_wr), .perf_n(perf_n),
    .sleep_n(sleep_n), .trim(trim), .sa_data(sa_data), .rd_data(rd_data),
    .wl_en(wl_en), .bl_en(bl_en), .dwl_sel(dwl_sel), .dw_mode(dw_mode),
    .sa_en(sa_en), .wd_en(wd_en), .wl_rst(wl_rst), .busy(busy)
  );

  typedef struct {
    bit rd; int len; int sa_idx; int wd_cnt; logic [15:0] out;
  } exp_t;
  exp_t q[$];

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int strobes();
    return int'({wl_en, bl_en, dwl_sel, sa_en, wd_en, wl_rst, busy});
  endfunction

  // Monitor: measures each access and compares it with the queued expectation
  int idx = 0, sa_cnt = 0, sa_at = -1, wd_cnt = 0, rst_at = -1;
  bit dm0 = 0, dm_ok = 1;
  always @(negedge clk) begin
    if (mon_en) begin
      if (busy) begin
        if (idx == 0) begin
          check(wl_en && bl_en && dwl_sel, "R4 open strobes", {wl_en, bl_en, dwl_sel}, 7);
          dm0 = dw_mode;
        end
        if (dw_mode != dm0) dm_ok = 0;
        if (sa_en) begin sa_cnt++; sa_at = idx; end
        if (wd_en) wd_cnt++;
        if (wl_rst) begin
          rst_at = idx;
          check(!wl_en, "R9 word line low at reset strobe", wl_en, 0);
        end
        idx++;
      end else if (idx > 0) begin
        exp_t e;
        if (q.size() == 0) check(0, "R10 unexpected access", 1, 0);
        else begin
          e = q.pop_front();
          check(idx == e.len, "R10 busy length", idx, e.len);
          check(dm0 == e.rd && dm_ok, "R3 dw_mode", dm0, e.rd);
          check(sa_cnt == (e.rd ? 1 : 0), "R6 sense pulse count", sa_cnt, e.rd ? 1 : 0);
          if (e.rd) check(sa_at == e.sa_idx, "R6 sense timing (R5 delay)", sa_at, e.sa_idx);
          check(wd_cnt == e.wd_cnt, "R8 write drive length (R5 delay)", wd_cnt, e.wd_cnt);
          check(rst_at == e.len - 1, "R9 reset strobe position", rst_at, e.len - 1);
          check(rd_data == e.out, "R7 read data", rd_data, e.out);
        end
        idx = 0; sa_cnt = 0; sa_at = -1; wd_cnt = 0; rst_at = -1; dm_ok = 1;
      end
    end
  end

  // Driver: queues the expectation, then holds a conflicting command while busy (R10)
  task automatic do_access(bit rd, bit slow, logic [3:0] a, logic [15:0] d);
    exp_t e;
    int l = slow ? 2 * int'(a) : int'(a);
    e.rd = rd; e.len = rd ? l + 3 : l + 2; e.sa_idx = l + 1;
    e.wd_cnt = rd ? 0 : l + 1; e.out = rd ? d : last_rd;
    q.push_back(e);
    rd_wr = rd; perf_n = !slow; trim = a; sa_data = d; cs_n = 0;
    @(negedge clk);
    rd_wr = !rd; perf_n = slow; trim = ~a;
    while (busy) @(negedge clk);
    cs_n = 1; rd_wr = rd;
    @(negedge clk);
    if (rd) last_rd = d;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(strobes() == 0, "R1 strobes after reset", strobes(), 0);
    check(rd_data == 0 && dw_mode == 0, "R1 latch after reset", rd_data, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    check(busy == 0 && strobes() == 0, "R2 no start with cs_n high", strobes(), 0);
    mon_en = 1;
    do_access(1, 0, 4'd3, 16'hA5C3);
    do_access(0, 0, 4'd2, 16'h1111);
    do_access(1, 1, 4'd5, 16'h0F0F);
    do_access(0, 1, 4'd4, 16'h2222);
    do_access(1, 0, 4'd0, 16'hBEEF);
    do_access(0, 0, 4'd0, 16'h3333);
    do_access(1, 1, 4'd15, 16'h7E81);
    do_access(0, 1, 4'd15, 16'h4444);
    mon_en = 0;
    // R2 / R11: sleep blocks a start
    sleep_n = 0; cs_n = 0; rd_wr = 1;
    repeat (3) begin
      @(negedge clk);
      check(strobes() == 0, "R11 asleep no start", strobes(), 0);
    end
    sleep_n = 1; cs_n = 1;
    @(negedge clk);
    // R11: sleep aborts a running slow read
    rd_wr = 1; perf_n = 0; trim = 4'd15; sa_data = 16'hDEAD; cs_n = 0;
    @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
    check(busy && wl_en, "R11 access running before sleep", {busy, wl_en}, 3);
    sleep_n = 0;
    @(negedge clk);
    check(strobes() == 0, "R11 abort drops strobes", strobes(), 0);
    check(rd_data == last_rd, "R7 abort keeps read data", rd_data, last_rd);
    @(negedge clk);
    check(strobes() == 0, "R11 stays quiet", strobes(), 0);
    sleep_n = 1;
    @(negedge clk);
    mon_en = 1;
    do_access(1, 0, 4'd1, 16'h5A5A);
    mon_en = 0;
    check(q.size() == 0, "R10 all accesses observed", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule